// File: doc/BRIEF.md
# Two-dimensional DMA address generator

This block turns one accepted transfer request into the ordered list of bus bursts that a DMA engine must issue. A request names a start address and a row stride for each of the two sides (source and destination), a row size in bytes minus one, a row count minus one, a small identifier and a repeat flag. The block walks the request row by row. Inside a row it offers bursts of up to `MAX_BEATS` bus beats at aligned addresses. After the last burst of a row it moves each side's row base forward by that side's stride.

A plain linear copy is a request with a row count field of zero. Once the final row is handed over, a normal request raises a single-cycle completion pulse that carries its identifier, and the block is then free for the next request. A request with the repeat flag set goes back to its start addresses instead and runs until reset. It produces no completion events. A side that is wired to a streaming peripheral instead of memory (`SRC_IS_MEM` / `DST_IS_MEM` = 0) has no address logic and drives zero.

The address of the burst on offer is always visible on the current-address outputs. Splitting bursts at bus boundaries, data buffering and the memory bus protocol are left to the logic around the block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `burst_valid` is 0, `done_pulse` is 0 and both current-address outputs are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 and `burst_valid` is 1. The first burst is at the request's start addresses with the low log2(`BEAT_BYTES`) bits forced to zero.
- R3: Each row carries (`req_x_len` >> log2(`BEAT_BYTES`)) + 1 beats, so the low bits of the row size are ignored. The row is split into bursts of `MAX_BEATS` beats, and the last burst carries the remainder. `burst_len_m1` is the burst's beat count minus one. Each burst inside a row starts `MAX_BEATS`*`BEAT_BYTES` bytes after the one before it.
- R4: A request has `req_y_len`+1 rows. Row r starts at that side's aligned start address plus r times that side's stride, with the stride's low log2(`BEAT_BYTES`) bits forced to zero. The two strides are independent, and addresses wrap modulo 2^`ADDR_W`.
- R5: While `burst_valid` is 1 and `burst_ready` is 0, the burst addresses and `burst_len_m1` hold their values.
- R6: For a request without the repeat flag, `done_pulse` is 1 for exactly one cycle. That cycle follows the clock edge that takes the last burst of the last row. In that cycle `done_id` equals the request's identifier and `req_ready` is 1.
- R7: For a request with the repeat flag, the burst after the last burst of the last row is the first burst of row 0 again. `done_pulse` never rises, and `req_ready` stays 0 until reset.
- R8: `cur_src_addr` and `cur_dst_addr` show the addresses of the burst on offer. They change only on a clock edge that takes a request or a burst. After completion they keep the addresses of the final burst.
- R9: A side configured as streaming drives 0 on its burst address and its current address for the whole request, while the other side behaves as in R2 to R4.
- R10: `req_valid` raised while a request is running is ignored, and the burst sequence of the running request is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_id | input | ID_W | Request identifier |
| req_src_addr | input | ADDR_W | Source start address |
| req_dst_addr | input | ADDR_W | Destination start address |
| req_src_stride | input | ADDR_W | Source row stride in bytes |
| req_dst_stride | input | ADDR_W | Destination row stride in bytes |
| req_x_len | input | LEN_W | Row size in bytes minus one |
| req_y_len | input | LEN_W | Row count minus one |
| req_cyclic | input | 1 | Repeat the request until reset |
| burst_valid | output | 1 | Burst offered |
| burst_ready | input | 1 | Burst taken by the bus side |
| burst_src_addr | output | ADDR_W | Source address of the burst |
| burst_dst_addr | output | ADDR_W | Destination address of the burst |
| burst_len_m1 | output | log2(MAX_BEATS) | Beats in the burst minus one |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_id | output | ID_W | Identifier of the completed request |
| cur_src_addr | output | ADDR_W | Current source address |
| cur_dst_addr | output | ADDR_W | Current destination address |

## Verification
Three situations are the hardest to reach from the ports. The first is the edge where the final burst of a row is taken while the bus is stalling. The second is the same edge on the final row, where a repeating request has to wrap back to its start without a completion strobe. The third is a new request pushed while one is still running. The stimulus sweeps every row length from one to nine beats with a burst cap of four, so each remainder size shows up against one, two and three rows. Back-pressure follows a fixed pattern that stalls row-end bursts. Some runs keep `req_valid` high with unrelated fields right up to the last burst. A repeating request is then followed through three full passes.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // true when v is a non-zero power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dma2d_side_walker.sv
// Address walker for one side of the transfer: row base plus burst offset.
module dma2d_side_walker #(
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BEATS  = 16,
   parameter bit IS_MEM     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              restart,
   input  logic              step_row,
   input  logic              step_burst,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BEAT_BYTES - 1);
   localparam logic [ADDR_W-1:0] BURST_STEP = ADDR_W'(MAX_BEATS * BEAT_BYTES);

   generate
      if (IS_MEM) begin : g_mem
         logic [ADDR_W-1:0] start_q;
         logic [ADDR_W-1:0] stride_q;
         logic [ADDR_W-1:0] row_base_q;
         logic [ADDR_W-1:0] addr_q;
         logic [ADDR_W-1:0] next_row;

         assign next_row = row_base_q + stride_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               start_q    <= '0;
               stride_q   <= '0;
               row_base_q <= '0;
               addr_q     <= '0;
            end else if (load) begin
               start_q    <= start_addr & ~ALIGN_MASK;
               stride_q   <= stride & ~ALIGN_MASK;
               row_base_q <= start_addr & ~ALIGN_MASK;
               addr_q     <= start_addr & ~ALIGN_MASK;
            end else if (restart) begin
               row_base_q <= start_q;
               addr_q     <= start_q;
            end else if (step_row) begin
               row_base_q <= next_row;
               addr_q     <= next_row;
            end else if (step_burst) begin
               addr_q     <= addr_q + BURST_STEP;
            end
         end

         assign addr = addr_q;
      end else begin : g_stream
         logic unused_side_inputs;
         assign unused_side_inputs = ^{clk, rst_n, load, restart, step_row,
                                       step_burst, start_addr, stride};
         assign addr = '0;
      end
   endgenerate

endmodule

// File: rtl/dma2d_beat_counter.sv
// Tracks beats left in the current row and the row index.
module dma2d_beat_counter #(
   parameter int LEN_W     = 16,
   parameter int SH        = 3,
   parameter int MAX_BEATS = 16,
   localparam int MB_W     = $clog2(MAX_BEATS),
   localparam int BW       = LEN_W - SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             accept,
   input  logic [LEN_W-1:0] x_len,
   input  logic [LEN_W-1:0] y_len,
   output logic [MB_W-1:0]  burst_len_m1,
   output logic             row_end,
   output logic             req_end
);

   localparam logic [BW-1:0]   CAP      = BW'(MAX_BEATS);
   localparam logic [MB_W-1:0] FULL_LEN = MB_W'(MAX_BEATS - 1);

   logic [BW-1:0]    row_beats_m1_q;
   logic [BW-1:0]    rem_m1_q;
   logic [LEN_W-1:0] rows_m1_q;
   logic [LEN_W-1:0] row_idx_q;

   assign row_end      = (rem_m1_q < CAP);
   assign req_end      = row_end && (row_idx_q == rows_m1_q);
   assign burst_len_m1 = row_end ? rem_m1_q[MB_W-1:0] : FULL_LEN;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_beats_m1_q <= '0;
         rem_m1_q       <= '0;
         rows_m1_q      <= '0;
         row_idx_q      <= '0;
      end else if (load) begin
         row_beats_m1_q <= BW'(x_len >> SH);
         rem_m1_q       <= BW'(x_len >> SH);
         rows_m1_q      <= y_len;
         row_idx_q      <= '0;
      end else if (accept) begin
         if (row_end) begin
            rem_m1_q  <= row_beats_m1_q;
            row_idx_q <= req_end ? '0 : row_idx_q + LEN_W'(1);
         end else begin
            rem_m1_q  <= rem_m1_q - CAP;
         end
      end
   end

endmodule

// File: rtl/dma2d_seq_ctrl.sv
// Request sequencer: idle/run state, repeat handling and completion strobe.
module dma2d_seq_ctrl
   import dma2d_pkg::*;
#(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   input  logic            req_cyclic,
   input  logic            burst_ready,
   input  logic            row_end,
   input  logic            req_end,
   output logic            req_ready,
   output logic            burst_valid,
   output logic            load,
   output logic            accept,
   output logic            restart,
   output logic            step_row,
   output logic            step_burst,
   output logic            done_pulse,
   output logic [ID_W-1:0] done_id
);

   seq_state_e      state_q;
   logic [ID_W-1:0] id_q;
   logic            cyc_q;
   logic            done_q;
   logic            finish;

   assign req_ready   = (state_q == SEQ_IDLE);
   assign burst_valid = (state_q == SEQ_RUN);
   assign load        = req_ready && req_valid;
   assign accept      = burst_valid && burst_ready;
   assign finish      = accept && req_end && !cyc_q;
   assign restart     = accept && req_end && cyc_q;
   assign step_row    = accept && row_end && !req_end;
   assign step_burst  = accept && !row_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         id_q    <= '0;
         cyc_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (load) begin
            state_q <= SEQ_RUN;
            id_q    <= req_id;
            cyc_q   <= req_cyclic;
         end else if (finish) begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   assign done_pulse = done_q;
   assign done_id    = id_q;

endmodule

// File: rtl/dma2d_addr_gen.sv
// Two-dimensional DMA address generator, top level.
module dma2d_addr_gen
   import dma2d_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BEATS  = 16,
   parameter int ID_W       = 4,
   parameter bit SRC_IS_MEM = 1'b1,
   parameter bit DST_IS_MEM = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ID_W-1:0]              req_id,
   input  logic [ADDR_W-1:0]            req_src_addr,
   input  logic [ADDR_W-1:0]            req_dst_addr,
   input  logic [ADDR_W-1:0]            req_src_stride,
   input  logic [ADDR_W-1:0]            req_dst_stride,
   input  logic [LEN_W-1:0]             req_x_len,
   input  logic [LEN_W-1:0]             req_y_len,
   input  logic                         req_cyclic,
   output logic                         burst_valid,
   input  logic                         burst_ready,
   output logic [ADDR_W-1:0]            burst_src_addr,
   output logic [ADDR_W-1:0]            burst_dst_addr,
   output logic [$clog2(MAX_BEATS)-1:0] burst_len_m1,
   output logic                         done_pulse,
   output logic [ID_W-1:0]              done_id,
   output logic [ADDR_W-1:0]            cur_src_addr,
   output logic [ADDR_W-1:0]            cur_dst_addr
);

   localparam int SH   = $clog2(BEAT_BYTES);
   localparam int MB_W = $clog2(MAX_BEATS);

   // elaboration-time parameter checks
   generate
      if (!is_pow2(BEAT_BYTES)) begin : g_bad_beat_bytes
         $error("BEAT_BYTES must be a power of two");
      end
      if (!is_pow2(MAX_BEATS) || MAX_BEATS < 2) begin : g_bad_max_beats
         $error("MAX_BEATS must be a power of two of at least 2");
      end
      if (LEN_W - SH <= MB_W) begin : g_bad_len_w
         $error("LEN_W too narrow for BEAT_BYTES and MAX_BEATS");
      end
      if (ADDR_W < SH + MB_W + 1) begin : g_bad_addr_w
         $error("ADDR_W too narrow for one burst step");
      end
   endgenerate

   logic load, accept, restart, step_row, step_burst;
   logic row_end, req_end;
   logic [ADDR_W-1:0] src_addr, dst_addr;

   dma2d_seq_ctrl #(
      .ID_W (ID_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_id      (req_id),
      .req_cyclic  (req_cyclic),
      .burst_ready (burst_ready),
      .row_end     (row_end),
      .req_end     (req_end),
      .req_ready   (req_ready),
      .burst_valid (burst_valid),
      .load        (load),
      .accept      (accept),
      .restart     (restart),
      .step_row    (step_row),
      .step_burst  (step_burst),
      .done_pulse  (done_pulse),
      .done_id     (done_id)
   );

   dma2d_beat_counter #(
      .LEN_W     (LEN_W),
      .SH        (SH),
      .MAX_BEATS (MAX_BEATS)
   ) beats_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .accept       (accept),
      .x_len        (req_x_len),
      .y_len        (req_y_len),
      .burst_len_m1 (burst_len_m1),
      .row_end      (row_end),
      .req_end      (req_end)
   );

   dma2d_side_walker #(
      .ADDR_W     (ADDR_W),
      .BEAT_BYTES (BEAT_BYTES),
      .MAX_BEATS  (MAX_BEATS),
      .IS_MEM     (SRC_IS_MEM)
   ) src_walk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .restart    (restart),
      .step_row   (step_row),
      .step_burst (step_burst),
      .start_addr (req_src_addr),
      .stride     (req_src_stride),
      .addr       (src_addr)
   );

   dma2d_side_walker #(
      .ADDR_W     (ADDR_W),
      .BEAT_BYTES (BEAT_BYTES),
      .MAX_BEATS  (MAX_BEATS),
      .IS_MEM     (DST_IS_MEM)
   ) dst_walk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .restart    (restart),
      .step_row   (step_row),
      .step_burst (step_burst),
      .start_addr (req_dst_addr),
      .stride     (req_dst_stride),
      .addr       (dst_addr)
   );

   assign burst_src_addr = src_addr;
   assign burst_dst_addr = dst_addr;
   assign cur_src_addr   = src_addr;
   assign cur_dst_addr   = dst_addr;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Protocol checker attached to the address generator.
module dma2d_addr_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int ID_W   = 4,
   parameter int MB_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_cyclic,
   input logic              burst_valid,
   input logic              burst_ready,
   input logic [ADDR_W-1:0] burst_src_addr,
   input logic [ADDR_W-1:0] burst_dst_addr,
   input logic [MB_W-1:0]   burst_len_m1,
   input logic              done_pulse,
   input logic [ID_W-1:0]   done_id,
   input logic [ADDR_W-1:0] cur_src_addr,
   input logic [ADDR_W-1:0] cur_dst_addr
);

   logic cyc_seen;
   logic unused_chk;
   assign unused_chk = ^done_id;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cyc_seen <= 1'b0;
      else if (req_valid && req_ready) cyc_seen <= req_cyclic;
   end

   // R5: a stalled burst keeps its fields
   a_r5_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_src_addr)
         && $stable(burst_dst_addr) && $stable(burst_len_m1)));

   // R6: completion strobe lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   // R6: block is free again when completion is signalled
   a_r6_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (req_ready && !burst_valid));

   // R7: a repeating request never completes
   a_r7_no_done_cyclic: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> !cyc_seen);

   // R8: current addresses move only on a request or burst handshake
   a_r8_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(burst_valid && burst_ready) && !(req_valid && req_ready))
         |=> ($stable(cur_src_addr) && $stable(cur_dst_addr)));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
   .ADDR_W (ADDR_W),
   .ID_W   (ID_W),
   .MB_W   ($clog2(MAX_BEATS))
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_cyclic     (req_cyclic),
   .burst_valid    (burst_valid),
   .burst_ready    (burst_ready),
   .burst_src_addr (burst_src_addr),
   .burst_dst_addr (burst_dst_addr),
   .burst_len_m1   (burst_len_m1),
   .done_pulse     (done_pulse),
   .done_id        (done_id),
   .cur_src_addr   (cur_src_addr),
   .cur_dst_addr   (cur_dst_addr)
);

// File: tb/dma2d_addr_gen_tb_top.sv
module dma2d_addr_gen_tb_top;

   localparam int AW = 16;
   localparam int LW = 8;
   localparam int BB = 4;
   localparam int MB = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [IW-1:0] req_id = '0;
   logic [AW-1:0] req_src_addr = '0, req_dst_addr = '0;
   logic [AW-1:0] req_src_stride = '0, req_dst_stride = '0;
   logic [LW-1:0] req_x_len = '0, req_y_len = '0;
   logic          req_cyclic = 1'b0;
   logic          burst_ready = 1'b0;

   logic          req_ready, burst_valid, done_pulse;
   logic [AW-1:0] burst_src_addr, burst_dst_addr, cur_src_addr, cur_dst_addr;
   logic [1:0]    burst_len_m1;
   logic [IW-1:0] done_id;

   logic          s_req_ready, s_burst_valid, s_done_pulse;
   logic [AW-1:0] s_burst_src_addr, s_burst_dst_addr, s_cur_src_addr, s_cur_dst_addr;
   logic [1:0]    s_burst_len_m1;
   logic [IW-1:0] s_done_id;

   dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .MAX_BEATS(MB),
                    .ID_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
      .req_src_stride(req_src_stride), .req_dst_stride(req_dst_stride),
      .req_x_len(req_x_len), .req_y_len(req_y_len), .req_cyclic(req_cyclic),
      .burst_valid(burst_valid), .burst_ready(burst_ready),
      .burst_src_addr(burst_src_addr), .burst_dst_addr(burst_dst_addr),
      .burst_len_m1(burst_len_m1), .done_pulse(done_pulse), .done_id(done_id),
      .cur_src_addr(cur_src_addr), .cur_dst_addr(cur_dst_addr));

   // second copy with a streaming destination side
   dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .MAX_BEATS(MB),
                    .ID_W(IW), .DST_IS_MEM(1'b0)) dut_stream_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(s_req_ready),
      .req_id(req_id), .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
      .req_src_stride(req_src_stride), .req_dst_stride(req_dst_stride),
      .req_x_len(req_x_len), .req_y_len(req_y_len), .req_cyclic(req_cyclic),
      .burst_valid(s_burst_valid), .burst_ready(burst_ready),
      .burst_src_addr(s_burst_src_addr), .burst_dst_addr(s_burst_dst_addr),
      .burst_len_m1(s_burst_len_m1), .done_pulse(s_done_pulse), .done_id(s_done_id),
      .cur_src_addr(s_cur_src_addr), .cur_dst_addr(s_cur_dst_addr));

   int  n_chk = 0;
   int  n_err = 0;
   int  bp_cnt = 0;
   bit  bp_on = 1'b0;
   bit  finished = 1'b0;

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_reset_state();
      check_eq("R1", "req_ready", 32'(req_ready), 1);
      check_eq("R1", "burst_valid", 32'(burst_valid), 0);
      check_eq("R1", "done_pulse", 32'(done_pulse), 0);
      check_eq("R1", "cur_src_addr", 32'(cur_src_addr), 0);
      check_eq("R1", "cur_dst_addr", 32'(cur_dst_addr), 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      burst_ready = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();
   endtask

   // Take one expected burst; called and returns at a falling edge.
   task automatic take(input logic [AW-1:0] es, input logic [AW-1:0] ed,
                       input int elen, input bit last, input bit junk, input bit cyc);
      bit            rdy;
      bit            stalled = 1'b0;
      logic [AW-1:0] hs = '0, hd = '0;
      logic [1:0]    hl = '0;
      int            guard = 0;
      forever begin
         if (stalled) begin
            check_eq("R5", "held src", 32'(burst_src_addr), 32'(hs));
            check_eq("R5", "held dst", 32'(burst_dst_addr), 32'(hd));
            check_eq("R5", "held len", 32'(burst_len_m1), 32'(hl));
         end
         if (burst_valid !== 1'b1) begin
            check_eq("R2", "burst_valid while running", 32'(burst_valid), 1);
            return;
         end
         rdy = !(bp_on && (bp_cnt % 3 == 1));
         bp_cnt++;
         burst_ready = rdy;
         if (junk && !last) begin
            req_valid = 1'b1;
            req_id = req_id + 2'd1;
            req_src_addr = 16'h5550;
            req_dst_addr = 16'h6660;
            req_x_len = 8'h07;
            req_y_len = 8'h00;
         end else begin
            req_valid = 1'b0;
         end
         if (rdy) begin
            check_eq("R3", "burst src", 32'(burst_src_addr), 32'(es));
            check_eq("R4", "burst dst", 32'(burst_dst_addr), 32'(ed));
            check_eq("R3", "burst len", 32'(burst_len_m1), 32'(elen - 1));
            check_eq("R8", "cur src", 32'(cur_src_addr), 32'(es));
            check_eq("R8", "cur dst", 32'(cur_dst_addr), 32'(ed));
            check_eq("R9", "stream dst addr", 32'(s_burst_dst_addr), 0);
            check_eq("R9", "stream cur dst", 32'(s_cur_dst_addr), 0);
            check_eq("R9", "stream src addr", 32'(s_burst_src_addr), 32'(es));
            if (cyc) check_eq("R7", "no done in repeat", 32'(done_pulse), 0);
            @(negedge clk);
            burst_ready = 1'b0;
            return;
         end
         stalled = 1'b1;
         hs = burst_src_addr;
         hd = burst_dst_addr;
         hl = burst_len_m1;
         guard++;
         if (guard > 20) begin
            check_eq("R5", "stall guard", 0, 1);
            return;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_req(input logic [IW-1:0] id, input logic [AW-1:0] src,
                          input logic [AW-1:0] dst, input logic [LW-1:0] xl,
                          input logic [LW-1:0] yl, input logic [AW-1:0] sstr,
                          input logic [AW-1:0] dstr, input bit cyc,
                          input int reps, input bit junk);
      int            beats, rows, rem, n, off;
      logic [AW-1:0] a_s, a_d, s_s, s_d, es, ed;
      bit            last;
      check_eq("R2", "req_ready idle", 32'(req_ready), 1);
      req_valid = 1'b1;
      req_id = id;
      req_src_addr = src;
      req_dst_addr = dst;
      req_x_len = xl;
      req_y_len = yl;
      req_src_stride = sstr;
      req_dst_stride = dstr;
      req_cyclic = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      check_eq("R2", "req_ready busy", 32'(req_ready), 0);
      beats = (int'(xl) >> 2) + 1;
      rows = int'(yl) + 1;
      a_s = src & ~16'h3;
      a_d = dst & ~16'h3;
      s_s = sstr & ~16'h3;
      s_d = dstr & ~16'h3;
      es = a_s;
      ed = a_d;
      for (int rep = 0; rep < reps; rep++) begin
         for (int r = 0; r < rows; r++) begin
            off = 0;
            rem = beats;
            while (rem > 0) begin
               n = (rem > MB) ? MB : rem;
               last = !cyc && (r == rows - 1) && (rem <= MB);
               es = a_s + AW'(r) * s_s + AW'(off);
               ed = a_d + AW'(r) * s_d + AW'(off);
               take(es, ed, n, last, junk, cyc);
               off += n * BB;
               rem -= n;
            end
         end
      end
      if (!cyc) begin
         check_eq("R6", "done_pulse", 32'(done_pulse), 1);
         check_eq("R6", "done_id", 32'(done_id), 32'(id));
         check_eq("R6", "req_ready at done", 32'(req_ready), 1);
         check_eq("R8", "cur src after done", 32'(cur_src_addr), 32'(es));
         check_eq("R8", "cur dst after done", 32'(cur_dst_addr), 32'(ed));
         @(negedge clk);
         check_eq("R6", "done_pulse one cycle", 32'(done_pulse), 0);
      end else begin
         check_eq("R7", "done_pulse after wrap", 32'(done_pulse), 0);
         check_eq("R7", "req_ready stays low", 32'(req_ready), 0);
         check_eq("R7", "back at start src", 32'(burst_src_addr), 32'(a_s));
      end
   endtask

   initial begin : main
      do_reset();
      // R3 R4 R10: sweep row length and row count
      for (int b = 1; b <= 9; b++) begin
         for (int r = 1; r <= 3; r++) begin
            bp_on = ((b + r) % 2) == 1;
            run_req(IW'(b + r), AW'(16'h1000 + b * 16'h100 + r),
                    AW'(16'h8000 - b * 64 + 2), LW'((b - 1) * 4 + (b % 4)),
                    LW'(r - 1), AW'(16'h40 + b * 8 + 1), AW'(16'h300 - r * 16),
                    1'b0, 1, (b % 3) == 0);
         end
      end
      // R3: largest row size, single row
      bp_on = 1'b1;
      run_req(2'd1, 16'h2000, 16'h3000, 8'hFF, 8'h00, 16'h0, 16'h0, 1'b0, 1, 1'b0);
      // R4: wrap-around of address arithmetic, zero stride on one side
      run_req(2'd2, 16'hFFE0, 16'h0100, 8'h17, 8'h02, 16'h0010, 16'h0000,
              1'b0, 1, 1'b1);
      // R7: repeating request, three passes
      bp_on = 1'b1;
      run_req(2'd3, 16'h4000, 16'h9000, 8'd19, 8'd1, 16'h0100, 16'h0040,
              1'b1, 3, 1'b0);
      do_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule